// File: doc/BRIEF.md
# Programmable TFT Sync Timing Generator

This block produces the pixel clock and the line and frame synchronisation for an RGB panel driven directly, with no controller of its own on the panel side. It divides the internal clock into a programmable pixel period and walks a horizontal counter through four regions in each line: sync pulse, back porch, active pixels, then front porch. A vertical counter walks the same four regions, counted in lines. From these counters it drives the pixel clock, horizontal sync, vertical sync, data-enable and panel select pins. Each pin has its own polarity bit.

While a pixel is visible, the block reports its column and row. It also issues a one-cycle request strobe and a data-valid window, both placed a programmable number of internal cycles around the active pixel-clock edge. A fetch unit uses the strobe to launch RGB data and the window to hold it. Output starts a programmable number of internal cycles after the drive enable is raised. Dropping the enable parks every pin at its inactive level and clears all counters. Timing fields are meant to be changed only while the drive enable is low.

Top module: `tft_sync_gen`

## Requirements
- R1: During reset, and while `driveEn` is low, every pin output sits at its inactive level (the inverse of its polarity bit), and `pixX`, `pixY`, `pixReq` and `rgbWin` are 0.
- R2: The pixel period P equals `dclkPeriod` internal cycles, and values 0 and 1 are treated as 2. In each period the raw pixel clock is inactive for the first floor(P/2) cycles and active for the rest, so the active edge falls at cycle floor(P/2) of the period. Every pin output lags the internal counters by one cycle.
- R3: A line lasts (hSyncM1+1) + hBack + (hActM1+1) + hFront pixels, in the order sync, back porch, active, front porch. Horizontal sync is active only during the first hSyncM1+1 pixels of every line.
- R4: A frame lasts (vSyncM1+1) + vBack + (vActM1+1) + vFront lines, in the same order. Vertical sync is active for whole lines, during the first vSyncM1+1 lines.
- R5: Data-enable is active only for pixels that lie inside both the horizontal active region and the vertical active region.
- R6: While data-enable is active, `pixX` and `pixY` give the 0-based column and row inside the active area. Otherwise both are 0.
- R7: For each visible pixel, `pixReq` pulses for one cycle at period cycle floor(P/2) − setupCyc, or at cycle 0 if setupCyc ≥ floor(P/2). `rgbWin` is high from that cycle through cycle floor(P/2) + holdCyc, clamped to P−1.
- R8: Polarity bit 1 makes a pin active-high and bit 0 makes it active-low, independently for pixel clock, horizontal sync, vertical sync, data-enable and panel select. Panel select is active whenever the generator is running.
- R9: After `driveEn` rises, the first pixel period begins `startPos` internal cycles later than it would for `startPos` = 0. Until then every pin stays inactive.
- R10: Dropping `driveEn` returns every pin to its inactive level within two cycles. Raising it again restarts the frame at line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous reset, active low |
| driveEn | input | 1 | Runs the generator while high |
| hActM1 | input | 10 | Visible pixels per line minus one |
| hBack | input | 8 | Horizontal back porch, in pixels |
| hFront | input | 8 | Horizontal front porch, in pixels |
| hSyncM1 | input | 7 | Horizontal sync width minus one |
| vActM1 | input | 10 | Visible lines per frame minus one |
| vBack | input | 8 | Vertical back porch, in lines |
| vFront | input | 8 | Vertical front porch, in lines |
| vSyncM1 | input | 7 | Vertical sync width minus one |
| dclkPeriod | input | 11 | Pixel period in internal cycles |
| startPos | input | 11 | Delay from enable to first pixel period |
| setupCyc | input | 2 | Data launch lead before the active edge |
| holdCyc | input | 2 | Data hold after the active edge |
| polDclk | input | 1 | Pixel clock polarity (1 = active high) |
| polHsync | input | 1 | Horizontal sync polarity |
| polVsync | input | 1 | Vertical sync polarity |
| polDataEn | input | 1 | Data-enable polarity |
| polCs | input | 1 | Panel select polarity |
| dclkOut | output | 1 | Pixel clock pin |
| hsyncOut | output | 1 | Horizontal sync pin |
| vsyncOut | output | 1 | Vertical sync pin |
| dataEnOut | output | 1 | Data-enable pin |
| csOut | output | 1 | Panel select pin |
| pixX | output | 10 | Visible column |
| pixY | output | 10 | Visible row |
| pixReq | output | 1 | One-cycle data launch request |
| rgbWin | output | 1 | Data setup-and-hold window |

## Verification
Four small panel geometries are each swept cycle by cycle over two whole frames. Every pin and coordinate is compared against values derived arithmetically from the timing fields. The first geometry has an odd start delay and unclamped setup and hold. The second uses zero porches, an odd period, inverted polarities and both clamps, which separates off-by-one region boundaries and setup/hold clamping errors from plain counting errors. The third uses the minimum period (field value 0), which exposes a missing period floor. The fourth uses a wider period, which pins down where the active edge sits within the period. Each sweep ends by dropping the enable, and the next sweep starts from the origin, so both parking and restart are checked.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;
  // Pin slots shared by the datapath and the top
  localparam int PIN_DCLK = 0;
  localparam int PIN_HS   = 1;
  localparam int PIN_VS   = 2;
  localparam int PIN_DE   = 3;
  localparam int PIN_CS   = 4;
  localparam int NPIN     = 5;

  typedef struct packed {
    logic running;   // generator past its start delay
    logic pixEnd;    // last internal cycle of a pixel period
    logic dclkRaw;   // pixel clock, active-high sense
    logic launch;    // data launch cycle within the period
    logic inWin;     // inside setup/hold window
    logic hSync;
    logic vSync;
    logic hAct;
    logic vAct;
  } tft_strobe_t;
endpackage

// File: rtl/tft_timing_ctrl.sv
module tft_timing_ctrl
  import tft_sync_pkg::*;
#(
  parameter int HW = 10,
  parameter int PW = 8,
  parameter int SW = 7,
  parameter int DW = 11,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          driveEn,
  input  logic [HW-1:0] hActM1,
  input  logic [PW-1:0] hBack,
  input  logic [PW-1:0] hFront,
  input  logic [SW-1:0] hSyncM1,
  input  logic [HW-1:0] vActM1,
  input  logic [PW-1:0] vBack,
  input  logic [PW-1:0] vFront,
  input  logic [SW-1:0] vSyncM1,
  input  logic [DW-1:0] dclkPeriod,
  input  logic [DW-1:0] startPos,
  input  logic [TW-1:0] setupCyc,
  input  logic [TW-1:0] holdCyc,
  output tft_strobe_t   strb,
  output logic [HW-1:0] hCoord,
  output logic [HW-1:0] vCoord
);
  localparam int MW = (HW > PW) ? ((HW > SW) ? HW : SW) : ((PW > SW) ? PW : SW);
  localparam int CW = MW + 2;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [DW-1:0] DTWO = DW'(2);

  // Pixel period and edge placement
  logic [DW-1:0] pEff, pLast, half, launchIdx, holdSum, holdEnd;
  logic [DW-1:0] divCnt, startCnt;
  logic          runQ;

  assign pEff      = (dclkPeriod < DTWO) ? DTWO : dclkPeriod;
  assign pLast     = pEff - DW'(1);
  assign half      = pEff >> 1;
  assign launchIdx = (DW'(setupCyc) >= half) ? '0 : half - DW'(setupCyc);
  assign holdSum   = half + DW'(holdCyc);
  assign holdEnd   = (holdSum > pLast) ? pLast : holdSum;

  // Region bounds, same ordering on both axes
  logic [CW-1:0] hSyncLen, hActStart, hActEnd, hLast;
  logic [CW-1:0] vSyncLen, vActStart, vActEnd, vLast;
  logic [CW-1:0] hCnt, vCnt;
  logic          hEnd, vEnd;

  assign hSyncLen  = CW'(hSyncM1) + ONE;
  assign hActStart = hSyncLen + CW'(hBack);
  assign hActEnd   = hActStart + CW'(hActM1) + ONE;
  assign hLast     = hActEnd + CW'(hFront) - ONE;
  assign vSyncLen  = CW'(vSyncM1) + ONE;
  assign vActStart = vSyncLen + CW'(vBack);
  assign vActEnd   = vActStart + CW'(vActM1) + ONE;
  assign vLast     = vActEnd + CW'(vFront) - ONE;
  assign hEnd      = (hCnt == hLast);
  assign vEnd      = (vCnt == vLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0; startCnt <= '0; divCnt <= '0; hCnt <= '0; vCnt <= '0;
    end else if (!driveEn) begin
      runQ <= 1'b0; startCnt <= '0; divCnt <= '0; hCnt <= '0; vCnt <= '0;
    end else if (!runQ) begin
      if (startCnt == startPos) runQ <= 1'b1;
      else                      startCnt <= startCnt + DW'(1);
    end else begin
      if (strb.pixEnd) begin
        divCnt <= '0;
        hCnt   <= hEnd ? '0 : hCnt + ONE;
        if (hEnd) vCnt <= vEnd ? '0 : vCnt + ONE;
      end else begin
        divCnt <= divCnt + DW'(1);
      end
    end
  end

  always_comb begin
    strb.running = runQ;
    strb.pixEnd  = runQ && (divCnt == pLast);
    strb.dclkRaw = runQ && (divCnt >= half);
    strb.launch  = runQ && (divCnt == launchIdx);
    strb.inWin   = runQ && (divCnt >= launchIdx) && (divCnt <= holdEnd);
    strb.hSync   = hCnt < hSyncLen;
    strb.vSync   = vCnt < vSyncLen;
    strb.hAct    = (hCnt >= hActStart) && (hCnt < hActEnd);
    strb.vAct    = (vCnt >= vActStart) && (vCnt < vActEnd);
  end

  assign hCoord = HW'(hCnt - hActStart);
  assign vCoord = HW'(vCnt - vActStart);

  // R2: a period always restarts at cycle 0
  p_div_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pixEnd |=> (divCnt == '0));
  // R7: launch is a single-cycle strobe
  p_launch_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> !strb.launch);
  // R9: running begins only once the start delay has elapsed
  p_start_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (startCnt == startPos));
  // R3: line counter wraps at the end of a line
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pixEnd && hEnd && driveEn) |=> (hCnt == '0));
endmodule

// File: rtl/tft_pin_dp.sv
module tft_pin_dp
  import tft_sync_pkg::*;
#(
  parameter int HW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  tft_strobe_t     strb,
  input  logic [HW-1:0]   hCoord,
  input  logic [HW-1:0]   vCoord,
  input  logic [NPIN-1:0] pol,
  output logic [NPIN-1:0] pinOut,
  output logic [HW-1:0]   pixX,
  output logic [HW-1:0]   pixY,
  output logic            pixReq,
  output logic            rgbWin
);
  logic [NPIN-1:0] actQ;   // active-sense pin state
  logic            visible;

  assign visible = strb.hAct && strb.vAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ <= '0; pixX <= '0; pixY <= '0; pixReq <= 1'b0; rgbWin <= 1'b0;
    end else if (!strb.running) begin
      actQ <= '0; pixX <= '0; pixY <= '0; pixReq <= 1'b0; rgbWin <= 1'b0;
    end else begin
      actQ[PIN_DCLK] <= strb.dclkRaw;
      actQ[PIN_HS]   <= strb.hSync;
      actQ[PIN_VS]   <= strb.vSync;
      actQ[PIN_DE]   <= visible;
      actQ[PIN_CS]   <= 1'b1;
      pixX   <= visible ? hCoord : '0;
      pixY   <= visible ? vCoord : '0;
      pixReq <= visible && strb.launch;
      rgbWin <= visible && strb.inWin;
    end
  end

  // Per-pin polarity: bit set means active-high
  for (genvar g = 0; g < NPIN; g++) begin : g_pol
    assign pinOut[g] = actQ[g] ~^ pol[g];
  end

  // R5: data-enable never outside an active panel select
  p_de_in_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    actQ[PIN_DE] |-> actQ[PIN_CS]);
  // R10: stopping parks every pin
  p_park_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.running |=> (actQ == '0));
  // R7: the request lies inside the data window
  p_req_in_win_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |-> rgbWin);
  // R6: coordinates are zero outside the visible area
  p_coord_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !actQ[PIN_DE] |-> (pixX == '0 && pixY == '0));
endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
#(
  parameter int HW = 10,
  parameter int PW = 8,
  parameter int SW = 7,
  parameter int DW = 11,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          driveEn,
  input  logic [HW-1:0] hActM1,
  input  logic [PW-1:0] hBack,
  input  logic [PW-1:0] hFront,
  input  logic [SW-1:0] hSyncM1,
  input  logic [HW-1:0] vActM1,
  input  logic [PW-1:0] vBack,
  input  logic [PW-1:0] vFront,
  input  logic [SW-1:0] vSyncM1,
  input  logic [DW-1:0] dclkPeriod,
  input  logic [DW-1:0] startPos,
  input  logic [TW-1:0] setupCyc,
  input  logic [TW-1:0] holdCyc,
  input  logic          polDclk,
  input  logic          polHsync,
  input  logic          polVsync,
  input  logic          polDataEn,
  input  logic          polCs,
  output logic          dclkOut,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          dataEnOut,
  output logic          csOut,
  output logic [HW-1:0] pixX,
  output logic [HW-1:0] pixY,
  output logic          pixReq,
  output logic          rgbWin
);
  tft_strobe_t     strb;
  logic [HW-1:0]   hCoord, vCoord;
  logic [NPIN-1:0] pol, pinOut;

  assign pol[PIN_DCLK] = polDclk;
  assign pol[PIN_HS]   = polHsync;
  assign pol[PIN_VS]   = polVsync;
  assign pol[PIN_DE]   = polDataEn;
  assign pol[PIN_CS]   = polCs;

  tft_timing_ctrl #(.HW(HW), .PW(PW), .SW(SW), .DW(DW), .TW(TW)) u_ctrl (
    .clk, .rstN, .driveEn, .hActM1, .hBack, .hFront, .hSyncM1,
    .vActM1, .vBack, .vFront, .vSyncM1, .dclkPeriod, .startPos,
    .setupCyc, .holdCyc, .strb, .hCoord, .vCoord
  );

  tft_pin_dp #(.HW(HW)) u_dp (
    .clk, .rstN, .strb, .hCoord, .vCoord, .pol, .pinOut,
    .pixX, .pixY, .pixReq, .rgbWin
  );

  assign dclkOut   = pinOut[PIN_DCLK];
  assign hsyncOut  = pinOut[PIN_HS];
  assign vsyncOut  = pinOut[PIN_VS];
  assign dataEnOut = pinOut[PIN_DE];
  assign csOut     = pinOut[PIN_CS];
endmodule

// File: tb/tb_tft_sync_gen.sv
`timescale 1ns/1ps
module tb_tft_sync_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic driveEn = 1'b0;
  logic [9:0] hActM1 = '0, vActM1 = '0;
  logic [7:0] hBack = '0, hFront = '0, vBack = '0, vFront = '0;
  logic [6:0] hSyncM1 = '0, vSyncM1 = '0;
  logic [10:0] dclkPeriod = '0, startPos = '0;
  logic [1:0] setupCyc = '0, holdCyc = '0;
  logic polDclk = 1'b1, polHsync = 1'b1, polVsync = 1'b1, polDataEn = 1'b1, polCs = 1'b1;
  logic dclkOut, hsyncOut, vsyncOut, dataEnOut, csOut, pixReq, rgbWin;
  logic [9:0] pixX, pixY;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tft_sync_gen dut (
    .clk, .rstN, .driveEn, .hActM1, .hBack, .hFront, .hSyncM1,
    .vActM1, .vBack, .vFront, .vSyncM1, .dclkPeriod, .startPos,
    .setupCyc, .holdCyc, .polDclk, .polHsync, .polVsync, .polDataEn, .polCs,
    .dclkOut, .hsyncOut, .vsyncOut, .dataEnOut, .csOut,
    .pixX, .pixY, .pixReq, .rgbWin
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pin level for an active-sense value under a polarity bit
  function automatic int lvl(input int a, input logic p);
    return p ? a : (a == 0 ? 1 : 0);
  endfunction

  task automatic chkIdle(input string tag);
    chk({tag, " dclk"},  dclkOut,   lvl(0, polDclk));
    chk({tag, " hsync"}, hsyncOut,  lvl(0, polHsync));
    chk({tag, " vsync"}, vsyncOut,  lvl(0, polVsync));
    chk({tag, " de"},    dataEnOut, lvl(0, polDataEn));
    chk({tag, " cs"},    csOut,     lvl(0, polCs));
    chk({tag, " pixX"},  pixX, 0);
    chk({tag, " pixY"},  pixY, 0);
    chk({tag, " req"},   pixReq, 0);
    chk({tag, " win"},   rgbWin, 0);
  endtask

  // Sweep one configuration from enable through the given frame count
  task automatic sweep(input int frames);
    int p, hlf, li, he, hs, ha0, ha1, ht, vs, va0, va1, vt, s, total;
    p   = (dclkPeriod < 2) ? 2 : int'(dclkPeriod);
    hlf = p / 2;
    li  = (int'(setupCyc) >= hlf) ? 0 : hlf - int'(setupCyc);
    he  = (hlf + int'(holdCyc) > p - 1) ? p - 1 : hlf + int'(holdCyc);
    hs  = int'(hSyncM1) + 1;  ha0 = hs + int'(hBack);  ha1 = ha0 + int'(hActM1) + 1;
    ht  = ha1 + int'(hFront);
    vs  = int'(vSyncM1) + 1;  va0 = vs + int'(vBack);  va1 = va0 + int'(vActM1) + 1;
    vt  = va1 + int'(vFront);
    s   = int'(startPos);
    total = s + 2 + frames * ht * vt * p;
    @(negedge clk); driveEn = 1'b1;
    for (int j = 1; j <= total; j++) begin
      int n, d, px, hc, vc, de;
      @(negedge clk);
      n = j - s - 2;
      if (n < 0) begin
        chkIdle("R9 start delay");
      end else begin
        d  = n % p;  px = n / p;
        hc = px % ht; vc = (px / ht) % vt;
        de = (hc >= ha0 && hc < ha1 && vc >= va0 && vc < va1) ? 1 : 0;
        chk("R2 dclk",  dclkOut,  lvl((d >= hlf) ? 1 : 0, polDclk));
        chk("R3 hsync", hsyncOut, lvl((hc < hs) ? 1 : 0, polHsync));
        chk("R4 vsync", vsyncOut, lvl((vc < vs) ? 1 : 0, polVsync));
        chk("R5 de",    dataEnOut, lvl(de, polDataEn));
        chk("R8 cs",    csOut,    lvl(1, polCs));
        chk("R6 pixX",  pixX, de ? hc - ha0 : 0);
        chk("R6 pixY",  pixY, de ? vc - va0 : 0);
        chk("R7 req",   pixReq, (de == 1 && d == li) ? 1 : 0);
        chk("R7 win",   rgbWin, (de == 1 && d >= li && d <= he) ? 1 : 0);
      end
    end
    @(negedge clk); driveEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chkIdle("R10 park");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // Config A: unclamped setup/hold, odd start delay
    hActM1 = 3; hBack = 2; hFront = 1; hSyncM1 = 1;
    vActM1 = 2; vBack = 1; vFront = 1; vSyncM1 = 0;
    dclkPeriod = 4; startPos = 3; setupCyc = 1; holdCyc = 1;
    repeat (3) @(negedge clk);
    chkIdle("R1 reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkIdle("R1 disabled");
    sweep(2);
    sweep(1);   // R10: restart begins again at the frame origin

    // Config B: zero porches, odd period, clamps, inverted polarities
    polDclk = 0; polHsync = 0; polVsync = 0; polDataEn = 0; polCs = 0;
    hActM1 = 1; hBack = 0; hFront = 0; hSyncM1 = 0;
    vActM1 = 1; vBack = 0; vFront = 1; vSyncM1 = 0;
    dclkPeriod = 5; startPos = 0; setupCyc = 3; holdCyc = 3;
    @(negedge clk);
    chkIdle("R8 R1 inverted idle");
    sweep(2);

    // Config C: period field 0 behaves as 2, mixed polarities
    polDclk = 1; polHsync = 0; polVsync = 1; polDataEn = 0; polCs = 1;
    hActM1 = 2; hBack = 1; hFront = 2; hSyncM1 = 2;
    vActM1 = 1; vBack = 2; vFront = 0; vSyncM1 = 1;
    dclkPeriod = 0; startPos = 1; setupCyc = 0; holdCyc = 0;
    sweep(2);

    // Config D: wider period, edge at cycle 3
    polDclk = 1; polHsync = 1; polVsync = 1; polDataEn = 1; polCs = 1;
    hActM1 = 3; hBack = 2; hFront = 1; hSyncM1 = 1;
    vActM1 = 2; vBack = 1; vFront = 1; vSyncM1 = 0;
    dclkPeriod = 7; startPos = 2; setupCyc = 2; holdCyc = 2;
    sweep(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule